// File: doc/BRIEF.md
# Endpoint Transfer-Done Interrupt Register

This block holds the transfer-done interrupt flags of a USB function controller with four endpoints. Every endpoint owns two flags, one for the transmit direction and one for the receive direction. The endpoint logic reports outcomes as single-cycle strobes. A successful acknowledged transfer and a transfer error that needs firmware attention both set the flag for that direction. Endpoints marked isochronous never raise a flag.

Firmware uses a plain write strobe and data byte to clear flags. It can also force flags on to test the interrupt path. An 8-bit enable mask selects which flags drive the single interrupt request. Each endpoint also has a NAK-interrupt enable and a void bit. When the NAK-interrupt enable is on and an IN token finds an empty transmit FIFO, the void bit is set. From then on the transmit flag stays pending until firmware clears either the void bit or the NAK-interrupt enable.

Top module: `ep_done_irq`

## Requirements
- R1: After reset, the flag, mask, void and NAK-enable registers all read zero and `irq` is low.
- R2: Flag bit 2*i belongs to the transmit direction of endpoint i. Bit 2*i+1 belongs to its receive direction. With four endpoints the byte reads, from bit 7 down: rx3 tx3 rx2 tx2 rx1 tx1 rx0 tx0.
- R3: The flag of the matching bit reads 1 on the cycle after any of these strobes is pulsed on a non-isochronous endpoint: `ev_tx_ok`, `ev_tx_err`, `ev_rx_ok` or `ev_rx_err`. Hardware never clears a flag.
- R4: When `ep_iso[i]` is 1, every event strobe of endpoint i is ignored, including `ev_in_empty`. The strobes change neither the flags nor the void bit.
- R5: A cycle with `flag_we` high loads `flag_wdata` into the flags. Writing 0 clears a bit and writing 1 sets it for test. Hardware sets and void persistence override this load.
- R6: If a hardware set and a firmware write of 0 reach the same bit in the same cycle, the bit reads 1 afterwards.
- R7: `ev_in_empty[i]` with `nak_en_q[i]` = 1 sets `void_q[i]` and the transmit flag of endpoint i on the next cycle.
- R8: While `void_q[i]` and `nak_en_q[i]` are both 1, transmit flag i reads 1 and a firmware clear has no effect on it. Clearing the void bit or the NAK enable releases the flag. Done in the same cycle as the flag clear, that release lets the flag reach 0.
- R9: `ev_in_empty[i]` while `nak_en_q[i]` = 0 changes neither the void bit nor any flag.
- R10: `irq` is a register that equals the OR over all bits of `flag_q & mask_q`. It changes on the same edge as the flags. Flags read back whatever the mask holds.
- R11: A cycle with `mask_we` high loads `mask_wdata` into the mask. The same scheme loads the void and NAK-enable registers from `void_we`/`void_wdata` and `nak_en_we`/`nak_en_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_ok | input | 4 | Per-endpoint strobe: transmit data acknowledged by host |
| ev_tx_err | input | 4 | Per-endpoint strobe: transmit error needing firmware |
| ev_rx_ok | input | 4 | Per-endpoint strobe: error-free receive data acknowledged |
| ev_rx_err | input | 4 | Per-endpoint strobe: receive error needing firmware |
| ev_in_empty | input | 4 | Per-endpoint strobe: IN token met an empty transmit FIFO |
| ep_iso | input | 4 | Per-endpoint isochronous configuration |
| flag_we | input | 1 | Firmware write strobe for the flags |
| flag_wdata | input | 8 | Firmware flag write data |
| mask_we | input | 1 | Firmware write strobe for the enable mask |
| mask_wdata | input | 8 | Enable mask write data |
| void_we | input | 1 | Firmware write strobe for the void bits |
| void_wdata | input | 4 | Void bit write data |
| nak_en_we | input | 1 | Firmware write strobe for the NAK-interrupt enables |
| nak_en_wdata | input | 4 | NAK-interrupt enable write data |
| flag_q | output | 8 | Current flags |
| mask_q | output | 8 | Current enable mask |
| void_q | output | 4 | Current void bits |
| nak_en_q | output | 4 | Current NAK-interrupt enables |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that every event strobe is a clean synchronous level. A strobe is sampled once per edge, so holding it for several cycles counts as repeated events. The assertions also take reset as held for at least one edge with all inputs idle. The bench drives every strobe and write on a falling edge, holds it for exactly one rising edge and returns it to zero before it samples. It asserts reset with all inputs at zero. This keeps each stimulus a single event whose result is visible on the next falling edge.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

  localparam int EP_NUM_DEF = 4;

  // Position of an endpoint's transmit-done flag in the flag word.
  function automatic int tx_pos(input int ep);
    return 2 * ep;
  endfunction

  // Position of an endpoint's receive-done flag: directly above transmit.
  function automatic int rx_pos(input int ep);
    return 2 * ep + 1;
  endfunction

endpackage

// File: rtl/ep_void_ctl.sv
module ep_void_ctl #(
  parameter int NUM_EP = ep_irq_pkg::EP_NUM_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_in_empty,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic              void_we,
  input  logic [NUM_EP-1:0] void_wdata,
  input  logic              nak_en_we,
  input  logic [NUM_EP-1:0] nak_en_wdata,
  output logic [NUM_EP-1:0] nak_evt,
  output logic [NUM_EP-1:0] persist_d,
  output logic [NUM_EP-1:0] void_q,
  output logic [NUM_EP-1:0] nak_en_q
);

  logic [NUM_EP-1:0] void_d;
  logic [NUM_EP-1:0] nak_en_d;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    // NAK returned on an empty FIFO, only when NAK interrupts are enabled
    assign nak_evt[i]   = ev_in_empty[i] & nak_en_q[i] & ~ep_iso[i];
    // hardware set of the void bit beats a same-cycle firmware clear
    assign void_d[i]    = (void_we ? void_wdata[i] : void_q[i]) | nak_evt[i];
    assign nak_en_d[i]  = nak_en_we ? nak_en_wdata[i] : nak_en_q[i];
    // persistence judged on next-state values so a release lands together
    // with a firmware flag clear
    assign persist_d[i] = void_d[i] & nak_en_d[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      void_q   <= '0;
      nak_en_q <= '0;
    end else begin
      void_q   <= void_d;
      nak_en_q <= nak_en_d;
    end
  end

endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank #(
  parameter int NUM_EP = ep_irq_pkg::EP_NUM_DEF,
  localparam int FW    = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_tx_ok,
  input  logic [NUM_EP-1:0] ev_tx_err,
  input  logic [NUM_EP-1:0] ev_rx_ok,
  input  logic [NUM_EP-1:0] ev_rx_err,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] persist_d,
  input  logic              flag_we,
  input  logic [FW-1:0]     flag_wdata,
  output logic [FW-1:0]     hw_set,
  output logic [FW-1:0]     force_set,
  output logic [FW-1:0]     flag_d,
  output logic [FW-1:0]     flag_q
);

  import ep_irq_pkg::*;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign hw_set[tx_pos(i)]    = (ev_tx_ok[i] | ev_tx_err[i]) & ~ep_iso[i];
    assign hw_set[rx_pos(i)]    = (ev_rx_ok[i] | ev_rx_err[i]) & ~ep_iso[i];
    assign force_set[tx_pos(i)] = persist_d[i];
    assign force_set[rx_pos(i)] = 1'b0;
  end

  logic [FW-1:0] base;
  assign base   = flag_we ? flag_wdata : flag_q;
  assign flag_d = base | hw_set | force_set;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen #(
  parameter int NUM_EP = ep_irq_pkg::EP_NUM_DEF,
  localparam int FW    = 2 * NUM_EP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] flag_d,
  input  logic          mask_we,
  input  logic [FW-1:0] mask_wdata,
  output logic [FW-1:0] mask_q,
  output logic          irq
);

  logic [FW-1:0] mask_d;
  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq    <= |(flag_d & mask_d);
    end
  end

endmodule

// File: rtl/ep_done_irq.sv
module ep_done_irq #(
  parameter int NUM_EP = ep_irq_pkg::EP_NUM_DEF,
  localparam int FW    = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_tx_ok,
  input  logic [NUM_EP-1:0] ev_tx_err,
  input  logic [NUM_EP-1:0] ev_rx_ok,
  input  logic [NUM_EP-1:0] ev_rx_err,
  input  logic [NUM_EP-1:0] ev_in_empty,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic              flag_we,
  input  logic [FW-1:0]     flag_wdata,
  input  logic              mask_we,
  input  logic [FW-1:0]     mask_wdata,
  input  logic              void_we,
  input  logic [NUM_EP-1:0] void_wdata,
  input  logic              nak_en_we,
  input  logic [NUM_EP-1:0] nak_en_wdata,
  output logic [FW-1:0]     flag_q,
  output logic [FW-1:0]     mask_q,
  output logic [NUM_EP-1:0] void_q,
  output logic [NUM_EP-1:0] nak_en_q,
  output logic              irq
);

  // named internal events, visible to the bound checker
  logic [NUM_EP-1:0] nak_evt;
  logic [NUM_EP-1:0] persist_d;
  logic [FW-1:0]     hw_set;
  logic [FW-1:0]     force_set;
  logic [FW-1:0]     flag_d;

  ep_void_ctl #(.NUM_EP(NUM_EP)) u_void (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_in_empty  (ev_in_empty),
    .ep_iso       (ep_iso),
    .void_we      (void_we),
    .void_wdata   (void_wdata),
    .nak_en_we    (nak_en_we),
    .nak_en_wdata (nak_en_wdata),
    .nak_evt      (nak_evt),
    .persist_d    (persist_d),
    .void_q       (void_q),
    .nak_en_q     (nak_en_q)
  );

  ep_flag_bank #(.NUM_EP(NUM_EP)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_tx_ok   (ev_tx_ok),
    .ev_tx_err  (ev_tx_err),
    .ev_rx_ok   (ev_rx_ok),
    .ev_rx_err  (ev_rx_err),
    .ep_iso     (ep_iso),
    .persist_d  (persist_d),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .hw_set     (hw_set),
    .force_set  (force_set),
    .flag_d     (flag_d),
    .flag_q     (flag_q)
  );

  ep_irq_gen #(.NUM_EP(NUM_EP)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_d     (flag_d),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_q     (mask_q),
    .irq        (irq)
  );

endmodule

// File: rtl/ep_done_irq_chk.sv
module ep_done_irq_chk #(
  parameter int NUM_EP = ep_irq_pkg::EP_NUM_DEF,
  localparam int FW    = 2 * NUM_EP
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_we,
  input logic [FW-1:0]     flag_wdata,
  input logic [FW-1:0]     hw_set,
  input logic [NUM_EP-1:0] nak_evt,
  input logic [NUM_EP-1:0] persist_d,
  input logic [FW-1:0]     flag_q,
  input logic [FW-1:0]     mask_q,
  input logic [NUM_EP-1:0] void_q,
  input logic [NUM_EP-1:0] nak_en_q,
  input logic              irq
);

  import ep_irq_pkg::*;

  logic [NUM_EP-1:0] tx_view;
  for (genvar i = 0; i < NUM_EP; i++) begin : g_tx
    assign tx_view[i] = flag_q[tx_pos(i)];
  end

  // R3
  hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));

  // R3
  no_hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R5
  fw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && hw_set == '0 && persist_d == '0) |=> (flag_q == $past(flag_wdata)));

  // R7
  void_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|nak_evt) |=> ((void_q & $past(nak_evt)) == $past(nak_evt)));

  // R8
  persist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_view & void_q & nak_en_q) == (void_q & nak_en_q)));

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == |(flag_q & mask_q)));

endmodule

bind ep_done_irq ep_done_irq_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flag_we    (flag_we),
  .flag_wdata (flag_wdata),
  .hw_set     (hw_set),
  .nak_evt    (nak_evt),
  .persist_d  (persist_d),
  .flag_q     (flag_q),
  .mask_q     (mask_q),
  .void_q     (void_q),
  .nak_en_q   (nak_en_q),
  .irq        (irq)
);

// File: tb/ep_done_irq_tb.sv
module ep_done_irq_tb;

  localparam int NE = 4;
  localparam int FW = 2 * NE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] ev_tx_ok = '0, ev_tx_err = '0, ev_rx_ok = '0, ev_rx_err = '0;
  logic [NE-1:0] ev_in_empty = '0, ep_iso = '0;
  logic flag_we = 1'b0, mask_we = 1'b0, void_we = 1'b0, nak_en_we = 1'b0;
  logic [FW-1:0] flag_wdata = '0, mask_wdata = '0;
  logic [NE-1:0] void_wdata = '0, nak_en_wdata = '0;
  logic [FW-1:0] flag_q, mask_q;
  logic [NE-1:0] void_q, nak_en_q;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ep_done_irq #(.NUM_EP(NE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err),
    .ev_rx_ok(ev_rx_ok), .ev_rx_err(ev_rx_err),
    .ev_in_empty(ev_in_empty), .ep_iso(ep_iso),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .void_we(void_we), .void_wdata(void_wdata),
    .nak_en_we(nak_en_we), .nak_en_wdata(nak_en_wdata),
    .flag_q(flag_q), .mask_q(mask_q), .void_q(void_q),
    .nak_en_q(nak_en_q), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one-cycle pulse: all strobes go back to zero on the next falling edge
  task automatic step();
    @(negedge clk);
    ev_tx_ok = '0; ev_tx_err = '0; ev_rx_ok = '0; ev_rx_err = '0;
    ev_in_empty = '0;
    flag_we = 1'b0; mask_we = 1'b0; void_we = 1'b0; nak_en_we = 1'b0;
  endtask

  task automatic wr_flags(input logic [FW-1:0] v);
    flag_we = 1'b1; flag_wdata = v; step();
  endtask

  task automatic wr_mask(input logic [FW-1:0] v);
    mask_we = 1'b1; mask_wdata = v; step();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", 32'(flag_q), 0);
    check("R1 mask", 32'(mask_q), 0);
    check("R1 void", 32'(void_q), 0);
    check("R1 nak_en", 32'(nak_en_q), 0);
    check("R1 irq", 32'(irq), 0);

    // R2 R3: every endpoint, every event kind lands on its own bit
    for (int ep = 0; ep < NE; ep++) begin
      for (int k = 0; k < 4; k++) begin
        wr_flags('0);
        case (k)
          0: ev_tx_ok[ep] = 1'b1;
          1: ev_tx_err[ep] = 1'b1;
          2: ev_rx_ok[ep] = 1'b1;
          default: ev_rx_err[ep] = 1'b1;
        endcase
        step();
        check("R2 R3 event bit", 32'(flag_q), 32'(1) << (2 * ep + (k >= 2 ? 1 : 0)));
        step();
        check("R3 flag held", 32'(flag_q), 32'(1) << (2 * ep + (k >= 2 ? 1 : 0)));
      end
    end

    // R4: isochronous endpoints ignore every strobe
    nak_en_we = 1'b1; nak_en_wdata = '1; step();
    check("R11 nak_en load", 32'(nak_en_q), 32'hF);
    for (int ep = 0; ep < NE; ep++) begin
      wr_flags('0);
      ep_iso = NE'(1) << ep;
      ev_tx_ok[ep] = 1'b1; ev_tx_err[ep] = 1'b1;
      ev_rx_ok[ep] = 1'b1; ev_rx_err[ep] = 1'b1; ev_in_empty[ep] = 1'b1;
      step();
      check("R4 iso flags", 32'(flag_q), 0);
      check("R4 iso void", 32'(void_q), 0);
    end
    ep_iso = '0;
    nak_en_we = 1'b1; nak_en_wdata = '0; step();

    // R5 R10 R11: all 256 firmware values with full mask
    wr_mask('1);
    check("R11 mask load", 32'(mask_q), 32'hFF);
    for (int v = 0; v < 256; v++) begin
      wr_flags(FW'(v));
      check("R5 fw load", 32'(flag_q), 32'(v));
      check("R10 irq full mask", 32'(irq), 32'(v != 0));
    end

    // R10: mask sweep with fixed flags, flags readable regardless
    wr_flags(8'h5A);
    for (int m = 0; m < 256; m++) begin
      wr_mask(FW'(m));
      check("R10 irq masked", 32'(irq), 32'((8'h5A & m) != 0));
      check("R10 flags visible", 32'(flag_q), 32'h5A);
    end
    wr_mask('1);

    // R6: set beats firmware clear in the same cycle
    wr_flags('1);
    flag_we = 1'b1; flag_wdata = '0; ev_tx_ok[2] = 1'b1; ev_rx_err[0] = 1'b1; step();
    check("R6 set wins", 32'(flag_q), 32'h12);

    // R9: empty IN with NAK interrupts disabled
    wr_flags('0);
    ev_in_empty = '1; step();
    check("R9 no void", 32'(void_q), 0);
    check("R9 no flag", 32'(flag_q), 0);

    // R7 R8: void set, persistence, release via void clear
    nak_en_we = 1'b1; nak_en_wdata = 4'b0100; step();
    ev_in_empty[2] = 1'b1; step();
    check("R7 void set", 32'(void_q), 32'b0100);
    check("R7 tx flag", 32'(flag_q), 32'h10);
    wr_flags('0);
    check("R8 persist", 32'(flag_q), 32'h10);
    check("R8 irq stays", 32'(irq), 1);
    void_we = 1'b1; void_wdata = '0; flag_we = 1'b1; flag_wdata = '0; step();
    check("R8 release void", 32'(flag_q), 0);
    check("R8 irq drops", 32'(irq), 0);

    // R8: release via NAK-enable clear, R11 void write
    ev_in_empty[2] = 1'b1; step();
    check("R7 void again", 32'(void_q), 32'b0100);
    nak_en_we = 1'b1; nak_en_wdata = '0; flag_we = 1'b1; flag_wdata = '0; step();
    check("R8 release nak", 32'(flag_q), 0);
    check("R11 void kept", 32'(void_q), 32'b0100);
    void_we = 1'b1; void_wdata = 4'b1001; step();
    check("R11 void load", 32'(void_q), 32'b1001);
    check("R8 no persist without nak_en", 32'(flag_q), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule